// File: doc/BRIEF.md
# Memory Chip-Select Unit

This block turns a 20-bit bus address in a 1-Mbyte memory space into active-low select lines for three kinds of memory region. The first is an upper window that always ends at FFFFFh. The second is a lower window that always starts at 00000h. The third is a relocatable midrange block split into four equal selects. The block also ends each bus cycle: it runs a wait-state counter and can optionally qualify the end of the cycle with an external ready line. It drives a single-cycle ready pulse back to the processor.

The processor starts a bus cycle with a one-cycle strobe while the address is valid. The selects for that address go low in that same cycle and stay low until the cycle ends. Software programs each region through a small write port. A write carries a region code and one 15-bit word that holds the size code, wait count, ready mode and enable, plus the midrange placement fields.

Overlapping regions are legal only when they agree on their wait and ready settings. When overlapping regions disagree, the unit uses the safest merged timing so that the cycle never hangs, and it raises an error output for the length of that cycle.

Top module: `memsel_unit`

## Requirements
- R1: After reset only the upper window is enabled. It covers F0000h to FFFFFh with three wait states and external ready required. The lower window and the midrange block are disabled. All selects are high, and `cpu_rdy` and `cfg_err` are low.
- R2: Writing with `cfg_sel`=0 programs the upper window. The word's bits [2:0] hold a size code c, and the window is the top 64 Kbytes shifted left by min(c,3) (64 to 512 Kbytes), ending at FFFFFh. Bits [4:3] hold the wait count, bit 5 sets ready-required and bit 6 is the enable.
- R3: Writing with `cfg_sel`=1 programs the lower window, using the same field layout as R2. When bit 6 is set, the window runs from 00000h up to 64 Kbytes shifted left by min(c,3). When bit 6 is clear, the lower select never asserts.
- R4: Writing with `cfg_sel`=2 programs the midrange block. It uses the fields of R2 plus bit 7 (whole-block mode) and bits [14:8] (base in 8-Kbyte units). The block size is 8 Kbytes shifted left by min(c,6), and base bits below the block size are ignored. Outside whole-block mode, `cs_mid_n[0]` to `cs_mid_n[3]` each cover one quarter of the block in ascending address order, and at most one of them is low. Writing with `cfg_sel`=3 changes nothing.
- R5: In whole-block mode, `cs_mid_n[0]` covers the entire midrange block and `cs_mid_n[3:1]` stay high.
- R6: Selects go low in the same cycle that `cyc_start` is high with a matching address. They hold their value until the cycle in which `cpu_rdy` pulses, and they are all high in the cycle after that.
- R7: With ready not required, `cpu_rdy` is a one-cycle pulse w+1 clocks after the start edge, where w is the wait count. `ardy` and `srdy` have no effect in this case.
- R8: With ready required, `cpu_rdy` pulses at the first cycle that is at least w+1 clocks after the start and in which ready is seen. `srdy` acts directly, and `ardy` passes through a two-flop synchronizer.
- R9: A cycle with `is_io` high asserts no memory select and ends one clock after the start.
- R10: An address outside every enabled region asserts no select and ends one clock after the start.
- R11: When more than one region is hit, the cycle uses the largest of their wait counts and requires ready if any of them does. `cfg_err` is high for the whole cycle when the hit regions differ in wait count or ready mode, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 20 | Bus address, valid while `cyc_start` is high |
| cyc_start | input | 1 | One-cycle bus-cycle start strobe |
| is_io | input | 1 | High for an I/O-space cycle |
| ardy | input | 1 | Asynchronous ready |
| srdy | input | 1 | Synchronous ready |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Region code: 0 upper, 1 lower, 2 midrange, 3 none |
| cfg_data | input | 15 | Configuration word |
| cs_upper_n | output | 1 | Upper-window select, active low |
| cs_lower_n | output | 1 | Lower-window select, active low |
| cs_mid_n | output | 4 | Midrange selects, active low |
| cpu_rdy | output | 1 | One-cycle end-of-cycle pulse to the processor |
| cfg_err | output | 1 | Conflicting settings on overlapping regions, held for the cycle |

## Verification
The hardest condition to reach from the ports is a conflicting overlap. Upper and lower windows can never overlap one another, so the only way to get one is to place the midrange block on top of the upper window with different timing. The bench does this by parking the block at F0000h with one wait state and no ready while the upper window keeps its three-wait, ready-required defaults. It then sweeps the address space and expects the merged latency together with `cfg_err`. Separate runs hold `srdy` low or raise `ardy` late to show that the synchronizer delay and the wait count combine as a maximum.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  localparam int AW   = 20;          // address bits (1 Mbyte)
  localparam int WSW  = 2;           // wait-count width
  localparam int KW   = 3;           // size-code width
  localparam int BW   = 7;           // midrange base width (8-Kbyte units)
  localparam int CFGW = BW + 8;      // configuration word width

  typedef struct packed {
    logic           en;
    logic           rdy;
    logic [WSW-1:0] ws;
    logic [KW-1:0]  k;
  } win_cfg_t;

  typedef struct packed {
    win_cfg_t      c;
    logic          whole;
    logic [BW-1:0] base;
  } mid_cfg_t;

  typedef enum logic [1:0] {
    SEL_UP   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_MID  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/memsel_cfg.sv
module memsel_cfg
  import memsel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [CFGW-1:0] data,
  output win_cfg_t        up_cfg,
  output win_cfg_t        lo_cfg,
  output mid_cfg_t        mid_cfg
);

  localparam win_cfg_t UP_RST  = '{en: 1'b1, rdy: 1'b1, ws: '1, k: '0};
  localparam win_cfg_t LO_RST  = '{en: 1'b0, rdy: 1'b0, ws: '0, k: '0};
  localparam mid_cfg_t MID_RST = '{c: LO_RST, whole: 1'b0, base: '0};

  win_cfg_t up_q, up_d, lo_q, lo_d, wr_win;
  mid_cfg_t mid_q, mid_d;
  logic     up_en, lo_en, mid_en;

  // field unpacking of the write word
  always_comb begin
    wr_win.k   = data[KW-1:0];
    wr_win.ws  = data[KW+WSW-1:KW];
    wr_win.rdy = data[KW+WSW];
    wr_win.en  = data[KW+WSW+1];
  end

  assign up_en  = we && (sel == SEL_UP);
  assign lo_en  = we && (sel == SEL_LO);
  assign mid_en = we && (sel == SEL_MID);

  always_comb begin
    up_d  = up_q;
    lo_d  = lo_q;
    mid_d = mid_q;
    if (up_en)  up_d = wr_win;
    if (lo_en)  lo_d = wr_win;
    if (mid_en) begin
      mid_d.c     = wr_win;
      mid_d.whole = data[KW+WSW+2];
      mid_d.base  = data[CFGW-1:CFGW-BW];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= UP_RST;
      lo_q  <= LO_RST;
      mid_q <= MID_RST;
    end else begin
      if (up_en)  up_q  <= up_d;
      if (lo_en)  lo_q  <= lo_d;
      if (mid_en) mid_q <= mid_d;
    end
  end

  assign up_cfg  = up_q;
  assign lo_cfg  = lo_q;
  assign mid_cfg = mid_q;

endmodule

// File: rtl/memsel_decode.sv
module memsel_decode
  import memsel_pkg::*;
#(
  parameter int UP_LG0   = 16,   // log2 of smallest upper/lower window
  parameter int UP_KMAX  = 3,    // largest effective upper/lower size code
  parameter int MID_LG0  = 13,   // log2 of smallest midrange block
  parameter int MID_KMAX = 6,    // largest effective midrange size code
  parameter int NMID     = 4     // midrange selects
) (
  input  logic [AW-1:0]   addr,
  input  logic            is_io,
  input  win_cfg_t        up_cfg,
  input  win_cfg_t        lo_cfg,
  input  mid_cfg_t        mid_cfg,
  output logic            hit_up,
  output logic            hit_lo,
  output logic [NMID-1:0] hit_mid,
  output logic [WSW-1:0]  ws_o,
  output logic            rdy_o,
  output logic            conflict_o
);

  localparam int LGW  = $clog2(AW + 1);
  localparam int QW   = $clog2(NMID);
  localparam int NREG = 3;

  logic [LGW-1:0] up_lg, lo_lg, mid_lg;
  logic [AW-1:0]  up_keep, lo_keep, mid_keep, mid_base;
  logic           up_in, lo_in, mid_in;
  logic [QW-1:0]  quarter;

  function automatic logic [LGW-1:0] eff_lg(input logic [KW-1:0] k, input int lg0, input int kmax);
    return (k > KW'(kmax)) ? LGW'(lg0 + kmax) : LGW'(lg0) + LGW'(k);
  endfunction

  always_comb begin
    up_lg    = eff_lg(up_cfg.k, UP_LG0, UP_KMAX);
    lo_lg    = eff_lg(lo_cfg.k, UP_LG0, UP_KMAX);
    mid_lg   = eff_lg(mid_cfg.c.k, MID_LG0, MID_KMAX);
    up_keep  = {AW{1'b1}} << up_lg;
    lo_keep  = {AW{1'b1}} << lo_lg;
    mid_keep = {AW{1'b1}} << mid_lg;
    mid_base = {mid_cfg.base, {(AW-BW){1'b0}}};
    up_in    = up_cfg.en  && !is_io && ((addr & up_keep) == up_keep);
    lo_in    = lo_cfg.en  && !is_io && ((addr & lo_keep) == '0);
    mid_in   = mid_cfg.c.en && !is_io && (((addr ^ mid_base) & mid_keep) == '0);
    quarter  = QW'(addr >> (mid_lg - LGW'(QW)));
  end

  assign hit_up = up_in;
  assign hit_lo = lo_in;

  for (genvar g = 0; g < NMID; g++) begin : g_mid
    if (g == 0) begin : g_first
      assign hit_mid[g] = mid_in && (mid_cfg.whole || (quarter == QW'(g)));
    end else begin : g_rest
      assign hit_mid[g] = mid_in && !mid_cfg.whole && (quarter == QW'(g));
    end
  end

  // merge timing across every region the address falls in
  logic [NREG-1:0] hv;
  win_cfg_t        cfgs [NREG];
  logic [WSW-1:0]  wmax, wmin;
  logic            ror, rand_;

  always_comb begin
    hv      = {mid_in, lo_in, up_in};
    cfgs[0] = up_cfg;
    cfgs[1] = lo_cfg;
    cfgs[2] = mid_cfg.c;
    wmax    = '0;
    wmin    = '1;
    ror     = 1'b0;
    rand_   = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      if (hv[i]) begin
        if (cfgs[i].ws > wmax) wmax = cfgs[i].ws;
        if (cfgs[i].ws < wmin) wmin = cfgs[i].ws;
        ror   = ror | cfgs[i].rdy;
        rand_ = rand_ & cfgs[i].rdy;
      end
    end
    ws_o       = wmax;
    rdy_o      = ror;
    conflict_o = ($countones(hv) >= 2) && ((wmax != wmin) || (ror != rand_));
  end

endmodule

// File: rtl/memsel_waitctl.sv
module memsel_waitctl #(
  parameter int WSW = 2,
  parameter int NCS = 6
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           start,
  input  logic [WSW-1:0] ws_in,
  input  logic           rdy_req_in,
  input  logic           conflict_in,
  input  logic [NCS-1:0] cs_in,
  input  logic           ardy,
  input  logic           srdy,
  output logic           busy,
  output logic           cpu_rdy,
  output logic           cfg_err,
  output logic [NCS-1:0] cs_hold
);

  logic           busy_q, busy_d;
  logic [WSW-1:0] cnt_q, cnt_d;
  logic           rreq_q, rreq_d;
  logic           err_q, err_d;
  logic [NCS-1:0] cs_q, cs_d;
  logic [1:0]     async_q;
  logic           rdy_seen, done, step_en, ctl_en;

  // two-flop capture of the asynchronous ready line
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) async_q <= '0;
    else         async_q <= {async_q[0], ardy};
  end

  assign rdy_seen = async_q[1] || srdy;
  assign done     = busy_q && (cnt_q == '0) && (!rreq_q || rdy_seen);
  assign step_en  = busy_q && !done && (cnt_q != '0);
  assign ctl_en   = start || done || step_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rreq_d = rreq_q;
    err_d  = err_q;
    cs_d   = cs_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = ws_in;
      rreq_d = rdy_req_in;
      err_d  = conflict_in;
      cs_d   = cs_in;
    end else if (done) begin
      busy_d = 1'b0;
      rreq_d = 1'b0;
      err_d  = 1'b0;
      cs_d   = '0;
    end else if (step_en) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rreq_q <= 1'b0;
      err_q  <= 1'b0;
      cs_q   <= '0;
    end else if (ctl_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rreq_q <= rreq_d;
      err_q  <= err_d;
      cs_q   <= cs_d;
    end
  end

  assign busy    = busy_q;
  assign cpu_rdy = done;
  assign cfg_err = err_q;
  assign cs_hold = cs_q;

  p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_rdy |=> !cpu_rdy)
    else $error("ready pulse longer than one cycle");

  p_ws_load_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && ws_in != '0) |=> !cpu_rdy)
    else $error("cycle ended before its wait states");

  p_err_span_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_err && !cpu_rdy) |=> cfg_err)
    else $error("conflict flag dropped mid-cycle");

endmodule

// File: rtl/memsel_unit.sv
module memsel_unit
  import memsel_pkg::*;
#(
  parameter int NMID = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            cyc_start,
  input  logic            is_io,
  input  logic            ardy,
  input  logic            srdy,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [CFGW-1:0] cfg_data,
  output logic            cs_upper_n,
  output logic            cs_lower_n,
  output logic [NMID-1:0] cs_mid_n,
  output logic            cpu_rdy,
  output logic            cfg_err
);

  localparam int NCS = NMID + 2;

  logic [1:0]      rsync_q;
  logic            rst_ni;
  win_cfg_t        up_cfg, lo_cfg;
  mid_cfg_t        mid_cfg;
  logic            hit_up, hit_lo;
  logic [NMID-1:0] hit_mid;
  logic [WSW-1:0]  ws_m;
  logic            rdy_m, conflict;
  logic            busy, start;
  logic [NCS-1:0]  cs_now, cs_hold, cs_act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  memsel_cfg u_cfg (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .data    (cfg_data),
    .up_cfg  (up_cfg),
    .lo_cfg  (lo_cfg),
    .mid_cfg (mid_cfg)
  );

  memsel_decode #(.NMID(NMID)) u_dec (
    .addr       (addr),
    .is_io      (is_io),
    .up_cfg     (up_cfg),
    .lo_cfg     (lo_cfg),
    .mid_cfg    (mid_cfg),
    .hit_up     (hit_up),
    .hit_lo     (hit_lo),
    .hit_mid    (hit_mid),
    .ws_o       (ws_m),
    .rdy_o      (rdy_m),
    .conflict_o (conflict)
  );

  assign start  = cyc_start && !busy;
  assign cs_now = {hit_mid, hit_lo, hit_up};

  memsel_waitctl #(.WSW(WSW), .NCS(NCS)) u_wait (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .start       (start),
    .ws_in       (ws_m),
    .rdy_req_in  (rdy_m),
    .conflict_in (conflict),
    .cs_in       (cs_now),
    .ardy        (ardy),
    .srdy        (srdy),
    .busy        (busy),
    .cpu_rdy     (cpu_rdy),
    .cfg_err     (cfg_err),
    .cs_hold     (cs_hold)
  );

  // decode drives the selects in the start cycle, the latch afterwards
  assign cs_act     = start ? cs_now : cs_hold;
  assign cs_upper_n = ~cs_act[0];
  assign cs_lower_n = ~cs_act[1];
  assign cs_mid_n   = ~cs_act[NCS-1:2];

  p_io_nocs_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && is_io) |-> (cs_upper_n && cs_lower_n && (&cs_mid_n)))
    else $error("memory select on an I/O cycle");

  p_mid_single_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(~cs_mid_n) <= 1)
    else $error("two midrange selects low");

  p_whole_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && mid_cfg.whole) |-> (&cs_mid_n[NMID-1:1]))
    else $error("upper midrange select in whole-block mode");

  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !cpu_rdy) |=> $stable({cs_upper_n, cs_lower_n, cs_mid_n}))
    else $error("select changed inside a cycle");

endmodule

// File: tb/memsel_unit_test.sv
`timescale 1ns/1ps
module memsel_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] addr;
  logic        cyc_start, is_io, ardy, srdy, cfg_we;
  logic [1:0]  cfg_sel;
  logic [14:0] cfg_data;
  logic        cs_upper_n, cs_lower_n, cpu_rdy, cfg_err;
  logic [3:0]  cs_mid_n;

  int n_tests = 0;
  int n_fail  = 0;

  // bench copy of the programmed configuration
  int uk = 0, uw = 3, ur = 1, ue = 1;
  int lk = 0, lw = 0, lr = 0, le = 0;
  int mk = 0, mw = 0, mr = 0, me = 0, mwh = 0, mb = 0;

  always #5 clk = ~clk;

  memsel_unit uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cyc_start(cyc_start), .is_io(is_io),
    .ardy(ardy), .srdy(srdy), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cs_upper_n(cs_upper_n), .cs_lower_n(cs_lower_n), .cs_mid_n(cs_mid_n),
    .cpu_rdy(cpu_rdy), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cs_vec();
    return {~cs_mid_n, ~cs_lower_n, ~cs_upper_n};
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic wr(input int sel, input int k, input int w, input int r, input int e,
                    input int wh, input int b);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = sel[1:0];
    cfg_data = {b[6:0], wh[0], e[0], r[0], w[1:0], k[2:0]};
    @(negedge clk);
    cfg_we   = 1'b0;
    if (sel == 0) begin uk = k; uw = w; ur = r; ue = e; end
    if (sel == 1) begin lk = k; lw = w; lr = r; le = e; end
    if (sel == 2) begin mk = k; mw = w; mr = r; me = e; mwh = wh; mb = b; end
  endtask

  task automatic expect_dec(input int a, input bit io, output int cs, output int w,
                            output bit rq, output bit err, output bit any);
    int us, ls, ms, mbase, q, n, wmax, wmin;
    bit uh, lh, mh, ror, rand_;
    us = 1 << (16 + imin(uk, 3));
    ls = 1 << (16 + imin(lk, 3));
    ms = 1 << (13 + imin(mk, 6));
    mbase = (mb << 13) & ~(ms - 1);
    uh = (ue != 0) && !io && (a >= (1 << 20) - us);
    lh = (le != 0) && !io && (a < ls);
    mh = (me != 0) && !io && (a >= mbase) && (a < mbase + ms);
    q  = (a - mbase) / (ms / 4);
    cs = 0;
    if (uh) cs |= 1;
    if (lh) cs |= 2;
    if (mh) cs |= (mwh != 0) ? 4 : (4 << q);
    n = 0; wmax = 0; wmin = 3; ror = 0; rand_ = 1;
    if (uh) begin n++; wmax = uw > wmax ? uw : wmax; wmin = imin(wmin, uw); ror |= ur[0]; rand_ &= ur[0]; end
    if (lh) begin n++; wmax = lw > wmax ? lw : wmax; wmin = imin(wmin, lw); ror |= lr[0]; rand_ &= lr[0]; end
    if (mh) begin n++; wmax = mw > wmax ? mw : wmax; wmin = imin(wmin, mw); ror |= mr[0]; rand_ &= mr[0]; end
    any = (n > 0);
    w   = any ? wmax : 0;
    rq  = any && ror;
    err = (n >= 2) && ((wmax != wmin) || (ror != rand_));
  endtask

  // rmode 0: srdy high; 1: srdy raised after rel edges; 2: ardy raised after rel edges
  task automatic run_cycle(input int a, input bit io, input int rmode, input int rel,
                           input string tag);
    int cs, w, lat, k, v;
    bit rq, err, any;
    expect_dec(a, io, cs, w, rq, err, any);
    lat = w + 1;
    if (rq && rmode == 1 && rel > lat) lat = rel;
    if (rq && rmode == 2 && rel + 2 > lat) lat = rel + 2;
    @(negedge clk);
    addr = a[19:0]; is_io = io; cyc_start = 1'b1;
    if (rmode == 1) begin srdy = (rel == 0); ardy = 1'b0; end
    if (rmode == 2) begin srdy = 1'b0; ardy = (rel == 0); end
    #1;
    v = cs_vec();
    chk(v == cs, tag, $sformatf("selects @%05h", a), v, cs);
    k = 0;
    for (int t = 0; t < 30; t++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (k == 1) cyc_start = 1'b0;
      if (rmode == 1 && k == rel) srdy = 1'b1;
      if (rmode == 2 && k == rel) ardy = 1'b1;
      #1;
      if (k == 1) chk(cfg_err == err, "R11", "cfg_err", cfg_err, err);
      v = cs_vec();
      chk(v == cs, "R6", "selects held", v, cs);
      if (cpu_rdy) break;
    end
    chk(k == lat, tag, $sformatf("latency @%05h", a), k, lat);
    if (rmode != 0) begin srdy = 1'b1; ardy = 1'b0; end
    @(posedge clk); @(negedge clk); #1;
    v = cs_vec();
    chk(v == 0 && !cpu_rdy, "R6", "released after end", v, 0);
    if (rmode != 0) repeat (3) @(negedge clk);
  endtask

  task automatic sweep(input bit io, input string tag);
    for (int i = 0; i < 256; i++)
      run_cycle((i << 12) | ((i * 37) & 12'hff0), io, 0, 0, tag);
  endtask

  initial begin
    #1_500_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; cyc_start = 0; is_io = 0; ardy = 0; srdy = 1;
    cfg_we = 0; cfg_sel = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cs_vec() == 0, "R1", "selects idle after reset", cs_vec(), 0);
    chk(!cpu_rdy && !cfg_err, "R1", "rdy/err after reset", {cpu_rdy, cfg_err}, 0);
    run_cycle(20'hFFFF0, 0, 0, 0, "R1");
    run_cycle(20'h00000, 0, 0, 0, "R1");
    sweep(0, "R1 R10");
    run_cycle(20'hFFFF0, 0, 1, 7, "R8");
    run_cycle(20'hF1230, 0, 1, 2, "R8");
    run_cycle(20'hFFFF0, 0, 2, 0, "R8");
    run_cycle(20'hF8000, 0, 2, 5, "R8");

    // split midrange block at 80000h, 128 Kbytes
    wr(0, 1, 1, 0, 1, 0, 0);
    wr(1, 0, 2, 0, 1, 0, 0);
    wr(2, 4, 0, 0, 1, 0, 8'h40);
    wr(3, 7, 3, 1, 1, 1, 8'h7f);   // R4: code 3 writes nothing
    sweep(0, "R2 R3 R4 R7");
    sweep(1, "R9");
    run_cycle(20'hFFFF0, 0, 1, 9, "R7");
    run_cycle(20'h12340, 0, 2, 9, "R7");

    // whole-block mode, unaligned base, clamped upper size
    wr(0, 7, 0, 0, 1, 0, 0);
    wr(1, 3, 1, 0, 0, 0, 0);
    wr(2, 2, 2, 0, 1, 1, 8'h11);
    sweep(0, "R2 R3 R5");

    // conflicting overlap of midrange and upper window
    wr(0, 0, 3, 1, 1, 0, 0);
    wr(2, 3, 1, 0, 1, 0, 8'h78);
    sweep(0, "R11");
    run_cycle(20'hF8000, 0, 1, 6, "R11");

    // matching overlap
    wr(2, 3, 3, 1, 1, 0, 8'h78);
    sweep(0, "R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule